// File: doc/BRIEF.md
# Quadrature Direct Digital Frequency Synthesizer

The block produces a pair of sampled waves, one cosine and one sine, whose frequency is set by an unsigned tuning word. A phase register adds the tuning word on every clock and drops the carry, so the phase wraps around a circle of 2^PHASE_W points. The phase value is the single address into two tables. Together the tables hold one full period of cosine and sine as signed fixed-point codes.

The table contents are computed at elaboration time from the parameters, so no initialisation file is needed. A real value of exactly +1.0 cannot be represented in the signed fraction format. It is stored as the largest positive code instead. A synchronous, active-high reset clears the phase, which defines sample index zero. The outputs follow the phase register combinationally, so the sample for index n is visible during the n-th cycle after reset. A change of the tuning word alters the step of the next accumulation and does not disturb the phase.

Top module: `quad_dds`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase becomes 0. In the following cycle `cos_out` is 0x7FF and `sin_out` is 0x000.
- R2: On each clock edge without reset, the phase advances by `freq_word`. In the n-th cycle after reset, the outputs are the codes for cos(2π·(n·k mod 512)/512) and sin(2π·(n·k mod 512)/512).
- R3: Each output is a 12-bit two's-complement code with 11 fractional bits. It equals floor(x·2048 + 0.5) for the real value x, and rounding is used for every entry.
- R4: A real value of +1.0 (cosine at phase 0, sine at phase 128) is clamped to 0x7FF.
- R5: A real value of −1.0 (cosine at phase 256, sine at phase 384) is represented exactly as 0x800.
- R6: The phase register is 9 bits wide and the carry is dropped, so accumulation wraps modulo 512. For example, `freq_word` = 511 steps the phase backwards by one point.
- R7: A new `freq_word` takes effect on the next accumulation, starting from the current phase, with no reset of the accumulator.
- R8: With `freq_word` = 0, the phase and both outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the phase |
| freq_word | input | 9 | Unsigned phase increment per clock |
| cos_out | output | 12 | Cosine sample, signed, 11 fractional bits |
| sin_out | output | 12 | Sine sample, signed, 11 fractional bits |

## Verification
The bench sweeps full periods at step 1 and step 99 and compares every sample against a reference that it computes in real arithmetic. This catches tables that are offset by one point, have swapped cosine and sine, or use truncation instead of rounding. It checks the peak codes directly. A design that wraps +1.0 would show 0x800 at phase 0, and one that clamps −1.0 would show 0x801 at phase 256. Separate checks cover a step of 511 that wraps on every clock, a step change in the middle of a run where a design that resets or skips a sample would lose phase continuity, a zero step that must freeze the outputs, and a reset in the middle of a run that must bring back the phase-0 codes on the very next cycle.

// File: rtl/quad_dds_pkg.sv
package quad_dds_pkg;

   typedef enum logic {
      QUANT_FLOOR = 1'b0,
      QUANT_NEAREST = 1'b1
   } quant_mode_e;

   typedef enum logic {
      WAVE_COS = 1'b0,
      WAVE_SIN = 1'b1
   } wave_sel_e;

   localparam real TWO_PI = 6.283185307179586;

   // Converts a real value to a signed fixed-point code with saturation.
   function automatic int to_fixed(real x, int frac_w, int out_w, quant_mode_e mode);
      real scaled;
      int  code;
      int  hi;
      int  lo;
      scaled = x * real'(1 << frac_w);
      if (mode == QUANT_NEAREST) code = $rtoi($floor(scaled + 0.5));
      else                       code = $rtoi($floor(scaled));
      hi = (1 << (out_w - 1)) - 1;
      lo = -(1 << (out_w - 1));
      if (code > hi) code = hi;
      if (code < lo) code = lo;
      return code;
   endfunction

   // Table entry for one phase point of the chosen wave.
   function automatic int wave_point(int idx, int phase_w, int frac_w, int out_w,
                                     quant_mode_e mode, wave_sel_e sel);
      real ang;
      real val;
      ang = TWO_PI * real'(idx) / real'(1 << phase_w);
      if (sel == WAVE_SIN) val = $sin(ang);
      else                 val = $cos(ang);
      return to_fixed(val, frac_w, out_w, mode);
   endfunction

endpackage

// File: rtl/quad_dds_phase_acc.sv
module quad_dds_phase_acc #(
   parameter int PHASE_W = 9,
   parameter int FREQ_W  = 9
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [FREQ_W-1:0]  step,
   output logic [PHASE_W-1:0] phase
);
   localparam logic [PHASE_W-1:0] PHASE_TOP = {PHASE_W{1'b1}};

   logic [PHASE_W-1:0] step_ext;
   logic [PHASE_W-1:0] phase_q;

   if (FREQ_W == PHASE_W) begin : g_step_same
      assign step_ext = step;
   end else begin : g_step_zext
      assign step_ext = {{(PHASE_W-FREQ_W){1'b0}}, step};
   end

   // Carry out of the sum is discarded: modulo 2^PHASE_W.
   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + step_ext;
   end

   assign phase = phase_q;

   p_clear_r1: assert property (@(posedge clk) rst |=> (phase == '0));

   p_advance_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (phase - $past(phase) == PHASE_W'($past(step))));

   p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
      (phase == PHASE_TOP && step == FREQ_W'(1)) |=> (phase == '0));

   p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
      (step == '0) |=> $stable(phase));

endmodule

// File: rtl/quad_dds_wave_rom.sv
module quad_dds_wave_rom
   import quad_dds_pkg::*;
#(
   parameter int          PHASE_W = 9,
   parameter int          OUT_W   = 12,
   parameter int          FRAC_W  = 11,
   parameter quant_mode_e QMODE   = QUANT_NEAREST,
   parameter wave_sel_e   WAVE    = WAVE_COS
) (
   input  logic [PHASE_W-1:0]      addr,
   output logic signed [OUT_W-1:0] data
);
   localparam int DEPTH = 1 << PHASE_W;

   logic signed [OUT_W-1:0] table_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      localparam int CODE = wave_point(i, PHASE_W, FRAC_W, OUT_W, QMODE, WAVE);
      assign table_q[i] = OUT_W'(CODE);
   end

   assign data = table_q[addr];

endmodule

// File: rtl/quad_dds.sv
module quad_dds
   import quad_dds_pkg::*;
#(
   parameter int          PHASE_W = 9,
   parameter int          FREQ_W  = 9,
   parameter int          OUT_W   = 12,
   parameter int          FRAC_W  = 11,
   parameter quant_mode_e QMODE   = QUANT_NEAREST
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [FREQ_W-1:0]       freq_word,
   output logic signed [OUT_W-1:0] cos_out,
   output logic signed [OUT_W-1:0] sin_out
);
   localparam int                      QUARTER  = 1 << (PHASE_W - 2);
   localparam int                      HALF     = 1 << (PHASE_W - 1);
   localparam logic signed [OUT_W-1:0] CODE_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] CODE_MIN = {1'b1, {(OUT_W-1){1'b0}}};

   if (FREQ_W > PHASE_W) begin : g_chk_freq
      $error("quad_dds: FREQ_W must not exceed PHASE_W");
   end
   if (PHASE_W < 3 || PHASE_W > 12) begin : g_chk_phase
      $error("quad_dds: PHASE_W out of supported range");
   end
   if (FRAC_W != OUT_W - 1) begin : g_chk_frac
      $error("quad_dds: format must be sign bit plus fraction");
   end

   logic [PHASE_W-1:0] phase;

   quad_dds_phase_acc #(
      .PHASE_W(PHASE_W),
      .FREQ_W (FREQ_W)
   ) u_acc (
      .clk  (clk),
      .rst  (rst),
      .step (freq_word),
      .phase(phase)
   );

   quad_dds_wave_rom #(
      .PHASE_W(PHASE_W),
      .OUT_W  (OUT_W),
      .FRAC_W (FRAC_W),
      .QMODE  (QMODE),
      .WAVE   (WAVE_COS)
   ) u_cos_rom (
      .addr(phase),
      .data(cos_out)
   );

   quad_dds_wave_rom #(
      .PHASE_W(PHASE_W),
      .OUT_W  (OUT_W),
      .FRAC_W (FRAC_W),
      .QMODE  (QMODE),
      .WAVE   (WAVE_SIN)
   ) u_sin_rom (
      .addr(phase),
      .data(sin_out)
   );

   p_reset_codes_r1: assert property (@(posedge clk)
      rst |=> (cos_out == CODE_MAX && sin_out == '0));

   p_cos_peak_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == '0) |-> (cos_out == CODE_MAX));

   p_sin_peak_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == PHASE_W'(QUARTER)) |-> (sin_out == CODE_MAX && cos_out == '0));

   p_cos_trough_r5: assert property (@(posedge clk) disable iff (rst)
      (phase == PHASE_W'(HALF)) |-> (cos_out == CODE_MIN));

   p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
      (freq_word == '0) |=> ($stable(cos_out) && $stable(sin_out)));

endmodule

// File: tb/quad_dds_bench.sv
module quad_dds_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [8:0]  freq_word = '0;
   logic signed [11:0] cos_out;
   logic signed [11:0] sin_out;

   int checks = 0;
   int fails  = 0;
   int ph     = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   quad_dds u_quad_dds (
      .clk      (clk),
      .rst      (rst),
      .freq_word(freq_word),
      .cos_out  (cos_out),
      .sin_out  (sin_out)
   );

   function automatic int ref_code(real x);
      int c;
      c = $rtoi($floor(x * 2048.0 + 0.5));
      if (c > 2047) c = 2047;
      if (c < -2048) c = -2048;
      return c;
   endfunction

   task automatic expect_val(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (phase %0d)", req, what, act, exp, ph);
      end
   endtask

   task automatic check_phase(string req);
      real ang;
      ang = 6.283185307179586 * real'(ph) / 512.0;
      expect_val(req, "cos", int'(cos_out), ref_code($cos(ang)));
      expect_val(req, "sin", int'(sin_out), ref_code($sin(ang)));
   endtask

   // Reset: asserted over two edges, released at a falling edge; phase is 0.
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      ph = 0;
   endtask

   task automatic step_cycle();
      @(negedge clk);
      ph = (ph + int'(freq_word)) % 512;
   endtask

   task automatic sweep(string req, int k, int count);
      freq_word = 9'(k);
      do_reset();
      for (int n = 0; n < count; n++) begin
         expect_val(req, "n*k phase", ph, (n * k) % 512);
         check_phase(req);
         if (ph == 0)   expect_val("R4", "cos at +1", int'(cos_out), 2047);
         if (ph == 128) expect_val("R4", "sin at +1", int'(sin_out), 2047);
         if (ph == 256) expect_val("R5", "cos at -1", int'(cos_out), -2048);
         if (ph == 384) expect_val("R5", "sin at -1", int'(sin_out), -2048);
         step_cycle();
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      freq_word = 9'd7;
      do_reset();
      expect_val("R1", "cos after reset", int'(cos_out), 2047);
      expect_val("R1", "sin after reset", int'(sin_out), 0);

      // R2 / R3: full periods at steps 1 and 99
      sweep("R2", 1, 512);
      sweep("R3", 99, 512);

      // R6: step 511 wraps backwards every clock
      sweep("R6", 511, 40);

      // R7: step change mid-run keeps phase continuous
      freq_word = 9'd3;
      do_reset();
      for (int n = 0; n < 10; n++) step_cycle();
      freq_word = 9'd100;
      expect_val("R7", "phase before change", ph, 30);
      check_phase("R7");
      step_cycle();
      expect_val("R7", "phase after change", ph, 130);
      check_phase("R7");
      for (int n = 0; n < 8; n++) begin
         step_cycle();
         check_phase("R7");
      end

      // R8: zero step freezes the outputs at the current phase
      begin
         int c0;
         int s0;
         freq_word = 9'd0;
         c0 = int'(cos_out);
         s0 = int'(sin_out);
         for (int n = 0; n < 16; n++) begin
            step_cycle();
            expect_val("R8", "cos held", int'(cos_out), c0);
            expect_val("R8", "sin held", int'(sin_out), s0);
         end
      end

      // R1: reset in mid-run returns to phase 0 on the next cycle
      freq_word = 9'd37;
      for (int n = 0; n < 5; n++) step_cycle();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      ph = 0;
      expect_val("R1", "cos after mid-run reset", int'(cos_out), 2047);
      expect_val("R1", "sin after mid-run reset", int'(sin_out), 0);
      step_cycle();
      check_phase("R1");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule